// File: doc/BRIEF.md
# Interrupt Flag and Wake Controller for a Small Microcontroller

This block collects three interrupt sources for a small 8-bit processor core. The first is an external pin, edge triggered, whose active edge is chosen by software. The second is a free-running timer value, watched for its wrap from all ones to zero. The third is the upper nibble of an input port, compared with a reference copy that is taken whenever the core reads the port. Each source has a sticky flag and an enable bit in a control register. That register also holds a global enable.

From these bits the block drives two outputs. One is an interrupt request that tells the core to vector. The other is a wake signal for the sleep logic. The wake signal ignores the global enable, so a sleeping core wakes on any enabled pending source. After waking, the core vectors only if the global enable is set. When the core takes the vector it strobes an acknowledge that clears the global enable. A return strobe sets it again. Software reads and writes the control register and a one-bit option register through a simple register port.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset the control register reads 0x00 and the option register reads 0x40, with the edge-select bit at bit 6 set to 1. The irq and wake outputs are 0.
- R2: With option bit 6 at 1, a low-to-high change on ext_pin sets control bit 1. The bit is visible after the third rising clock edge that follows the change: two synchronizer stages, then detection. A high-to-low change leaves bit 1 at 0.
- R3: With option bit 6 at 0, a high-to-low change on ext_pin sets control bit 1, and a low-to-high change does not. Changing bit 6 while the pin is steady sets no flag.
- R4: Control bit 2 is set when tmr_val holds 0xFF on one clock edge and 0x00 on the next. No other step sets it, including a jump to 0x00 from another value and the step 0x00 to 0x01.
- R5: Control bit 0 is set on every clock edge on which the synchronized port_hi differs from the reference value. A port_rd strobe loads the synchronized value into the reference. Both the synchronizer and the reference reset to 0.
- R6: Flags stay set until software writes them to 0. A write with reg_sel=0 loads bits 7, 5, 4, 3, 2, 1 and 0, and bit 6 always reads 0. A write with reg_sel=1 stores only bit 6, and the other option bits read 0. rd_data shows the control register when reg_sel=0 and the option register when reg_sel=1.
- R7: When a hardware flag-set event and a software write of 0 to that flag fall on the same clock edge, the flag ends up set.
- R8: irq is 1 exactly when control bit 7 is 1 and at least one pair has both bits set: bits 5 and 2 (timer), bits 4 and 1 (external), or bits 3 and 0 (port).
- R9: wake is 1 exactly when sleeping is 1 and at least one of those enable/flag pairs is set, whatever the value of bit 7.
- R10: vec_take clears bit 7 at the next edge, and irq_return sets it. vec_take wins over irq_return, and both win over a software write of bit 7 on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| port_hi | input | 4 | Asynchronous upper nibble of the input port |
| tmr_val | input | 8 | Current timer count |
| port_rd | input | 1 | Core read of the port; loads the change reference |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects option |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Selected register read data |
| vec_take | input | 1 | Core is taking the interrupt vector |
| irq_return | input | 1 | Return-from-interrupt strobe |
| sleeping | input | 1 | Core is in sleep |
| irq | output | 1 | Interrupt request to the core |
| wake | output | 1 | Wake request to the sleep logic |

## Verification
The external pin is driven with rising and falling changes under both edge-select settings, and the polarity is flipped while the pin is held steady. Together these separate true edge detection from level detection or an inverted polarity, and a check after two edges pins down the synchronizer latency. The timer is stepped through a genuine wrap, a jump to zero from another value and the step up from zero, which separates a wrap detector from a plain zero detector. The port nibble is checked with a persisting mismatch against a software clear and then after a reference reload. The remaining patterns land a flag event on the same edge as a clearing write, collide the vector and return strobes, and sweep the enable and global-enable combinations against the sleeping input.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_W      = 8;
    localparam int B_GIE      = 7;
    localparam int B_EDGE_SEL = 6;
    localparam logic [REG_W-1:0] OPT_RESET = 8'h40;

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_OPT  = 1'b1
    } reg_sel_e;

    // source events for one cycle; order matches the flag bits 2..0
    typedef struct packed {
        logic tmr_wrap;
        logic ext_edge;
        logic port_chg;
    } irq_evt_t;

    typedef struct packed {
        logic gie;
        logic tmr_en;
        logic ext_en;
        logic port_en;
        logic tmr_fl;
        logic ext_fl;
        logic port_fl;
    } ctrl_t;

    function automatic logic [REG_W-1:0] ctrl_to_bits(input ctrl_t c);
        return {c.gie, 1'b0, c.tmr_en, c.ext_en, c.port_en,
                c.tmr_fl, c.ext_fl, c.port_fl};
    endfunction

    function automatic ctrl_t bits_to_ctrl(input logic [REG_W-1:0] b);
        ctrl_t c;
        c.gie     = b[7];
        c.tmr_en  = b[5];
        c.ext_en  = b[4];
        c.port_en = b[3];
        c.tmr_fl  = b[2];
        c.ext_fl  = b[1];
        c.port_fl = b[0];
        return c;
    endfunction

    function automatic logic [2:0] pending(input ctrl_t c);
        return {c.tmr_en & c.tmr_fl, c.ext_en & c.ext_fl, c.port_en & c.port_fl};
    endfunction

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= '0;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/irqc_evt.sv
module irqc_evt
    import irqc_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int TMR_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_s,
    input  logic [PORT_W-1:0] port_s,
    input  logic [TMR_W-1:0]  tmr_val,
    input  logic              edge_rise,
    input  logic              port_rd,
    output irq_evt_t          evt
);
    logic              pin_prev;
    logic [PORT_W-1:0] port_ref;
    logic [TMR_W-1:0]  tmr_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_prev <= 1'b0;
            port_ref <= '0;
            tmr_prev <= '0;
        end else begin
            pin_prev <= pin_s;
            tmr_prev <= tmr_val;
            if (port_rd) port_ref <= port_s;
        end
    end

    always_comb begin
        evt.ext_edge = edge_rise ? (pin_s & ~pin_prev) : (~pin_s & pin_prev);
        evt.port_chg = |(port_s ^ port_ref);
        evt.tmr_wrap = (&tmr_prev) & (tmr_val == '0);
    end
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  irq_evt_t         evt,
    input  logic             vec_take,
    input  logic             irq_return,
    output ctrl_t            ctrl,
    output logic             edge_rise
);
    ctrl_t ctrl_q, ctrl_nx;
    logic  edge_q;

    always_comb begin
        ctrl_nx = ctrl_q;
        if (wr_en && wr_sel == SEL_CTRL) ctrl_nx = bits_to_ctrl(wr_data);
        if (irq_return) ctrl_nx.gie = 1'b1;
        if (vec_take)   ctrl_nx.gie = 1'b0;
        ctrl_nx.tmr_fl  = ctrl_nx.tmr_fl  | evt.tmr_wrap;
        ctrl_nx.ext_fl  = ctrl_nx.ext_fl  | evt.ext_edge;
        ctrl_nx.port_fl = ctrl_nx.port_fl | evt.port_chg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            edge_q <= OPT_RESET[B_EDGE_SEL];
        end else begin
            ctrl_q <= ctrl_nx;
            if (wr_en && wr_sel == SEL_OPT) edge_q <= wr_data[B_EDGE_SEL];
        end
    end

    assign ctrl      = ctrl_q;
    assign edge_rise = edge_q;
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irqc_pkg::*;
#(
    parameter int PORT_W = 4,
    parameter int TMR_W  = 8,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ext_pin,
    input  logic [PORT_W-1:0] port_hi,
    input  logic [TMR_W-1:0]  tmr_val,
    input  logic              port_rd,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              vec_take,
    input  logic              irq_return,
    input  logic              sleeping,
    output logic              irq,
    output logic              wake
);
    localparam int SW = PORT_W + 1;

    logic [SW-1:0]     sync_q;
    logic              pin_s;
    logic [PORT_W-1:0] port_s;
    logic              edge_rise;
    irq_evt_t          evt;
    ctrl_t             ctrl;
    reg_sel_e          sel;
    logic [2:0]        pend;
    logic [REG_W-1:0]  ctrl_view;
    logic              ext_hit;

    assign sel = reg_sel_e'(reg_sel);

    irqc_sync #(.W(SW), .STAGES(SYNC_N)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({ext_pin, port_hi}),
        .q   (sync_q)
    );

    assign pin_s  = sync_q[SW-1];
    assign port_s = sync_q[PORT_W-1:0];

    irqc_evt #(.PORT_W(PORT_W), .TMR_W(TMR_W)) u_evt (
        .clk       (clk),
        .rst       (rst),
        .pin_s     (pin_s),
        .port_s    (port_s),
        .tmr_val   (tmr_val),
        .edge_rise (edge_rise),
        .port_rd   (port_rd),
        .evt       (evt)
    );

    irqc_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (reg_wr),
        .wr_sel     (sel),
        .wr_data    (wr_data),
        .evt        (evt),
        .vec_take   (vec_take),
        .irq_return (irq_return),
        .ctrl       (ctrl),
        .edge_rise  (edge_rise)
    );

    assign pend      = pending(ctrl);
    assign ctrl_view = ctrl_to_bits(ctrl);
    assign ext_hit   = evt.ext_edge;
    assign irq       = ctrl.gie & (|pend);
    assign wake      = sleeping & (|pend);

    always_comb begin
        if (sel == SEL_OPT) begin
            rd_data             = '0;
            rd_data[B_EDGE_SEL] = edge_rise;
        end else begin
            rd_data = ctrl_view;
        end
    end
endmodule

// File: rtl/irqc_chk.sv
module irqc_chk (
    input logic       clk,
    input logic       rst,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic       vec_take,
    input logic       sleeping,
    input logic       irq,
    input logic       wake,
    input logic [7:0] ctrl_q,
    input logic       ext_evt
);
    // R8
    irq_needs_gie_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ctrl_q[7]);

    // R9
    wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (rst)
        wake |-> sleeping);

    // R10
    gie_clear_chk: assert property (@(posedge clk) disable iff (rst)
        vec_take |=> !ctrl_q[7]);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[1] && !(reg_wr && !reg_sel)) |=> ctrl_q[1]);

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        ext_evt |=> ctrl_q[1]);
endmodule

bind irq_flag_ctrl irqc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .reg_wr   (reg_wr),
    .reg_sel  (reg_sel),
    .vec_take (vec_take),
    .sleeping (sleeping),
    .irq      (irq),
    .wake     (wake),
    .ctrl_q   (ctrl_view),
    .ext_evt  (ext_hit)
);

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_pin = 1'b0;
    logic [3:0] port_hi = 4'h0;
    logic [7:0] tmr_val = 8'h00;
    logic       port_rd = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       vec_take = 1'b0;
    logic       irq_return = 1'b0;
    logic       sleeping = 1'b0;
    logic       irq;
    logic       wake;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    irq_flag_ctrl u_irq_flag_ctrl (
        .clk(clk), .rst(rst), .ext_pin(ext_pin), .port_hi(port_hi),
        .tmr_val(tmr_val), .port_rd(port_rd), .reg_wr(reg_wr),
        .reg_sel(reg_sel), .wr_data(wr_data), .rd_data(rd_data),
        .vec_take(vec_take), .irq_return(irq_return), .sleeping(sleeping),
        .irq(irq), .wake(wake)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_ctrl;
    logic       m_edge;
    logic [7:0] m_tprev;
    logic [3:0] m_ref;
    logic       pin_h[$];
    logic [3:0] port_h[$];

    function automatic logic m_pend(input logic [7:0] c);
        return (c[5] & c[2]) | (c[4] & c[1]) | (c[3] & c[0]);
    endfunction

    always @(posedge clk) begin : model
        logic ev_x, ev_p, ev_t, s2, pv;
        logic [3:0] ps2;
        logic [7:0] c;
        if (rst) begin
            m_ctrl = 8'h00; m_edge = 1'b1; m_tprev = 8'h00; m_ref = 4'h0;
            pin_h = '{1'b0, 1'b0, 1'b0};
            port_h = '{4'h0, 4'h0, 4'h0};
        end else begin
            s2 = pin_h[1]; pv = pin_h[0]; ps2 = port_h[1];
            ev_x = m_edge ? (s2 && !pv) : (!s2 && pv);
            ev_p = (ps2 != m_ref);
            ev_t = (m_tprev == 8'hFF) && (tmr_val == 8'h00);
            c = m_ctrl;
            if (reg_wr && !reg_sel) c = wr_data & 8'hBF;
            if (irq_return) c[7] = 1'b1;
            if (vec_take)   c[7] = 1'b0;
            if (ev_t) c[2] = 1'b1;
            if (ev_x) c[1] = 1'b1;
            if (ev_p) c[0] = 1'b1;
            m_ctrl = c;
            if (reg_wr && reg_sel) m_edge = wr_data[6];
            if (port_rd) m_ref = ps2;
            m_tprev = tmr_val;
            pin_h.push_back(ext_pin);  void'(pin_h.pop_front());
            port_h.push_back(port_hi); void'(port_h.pop_front());
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R6 rd_data per cycle", rd_data,
                reg_sel ? {1'b0, m_edge, 6'b0} : m_ctrl);
            chk("R8 irq per cycle", {7'b0, irq}, {7'b0, m_ctrl[7] & m_pend(m_ctrl)});
            chk("R9 wake per cycle", {7'b0, wake}, {7'b0, sleeping & m_pend(m_ctrl)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        reg_wr = 1'b1; reg_sel = sel; wr_data = d;
        step(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, input string tag, input logic [7:0] exp);
        reg_sel = sel;
        #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        rd(1'b0, "R1 control reset", 8'h00);
        rd(1'b1, "R1 option reset", 8'h40);
        chk("R1 irq reset", {7'b0, irq}, 8'h00);
        chk("R1 wake reset", {7'b0, wake}, 8'h00);

        // R2 rising edge, latency, falling ignored
        ext_pin = 1'b1;
        step(2);
        rd(1'b0, "R2 not yet after two edges", 8'h00);
        step(1);
        rd(1'b0, "R2 rising edge sets bit 1", 8'h02);
        wr(1'b0, 8'h00);
        ext_pin = 1'b0;
        step(4);
        rd(1'b0, "R2 falling edge ignored", 8'h00);

        // R3 falling-edge mode
        wr(1'b1, 8'h00);
        step(4);
        rd(1'b0, "R3 polarity change with steady pin", 8'h00);
        ext_pin = 1'b1;
        step(4);
        rd(1'b0, "R3 rising ignored in falling mode", 8'h00);
        ext_pin = 1'b0;
        step(3);
        rd(1'b0, "R3 falling edge sets bit 1", 8'h02);

        // R6 sticky flags and register fields
        step(10);
        rd(1'b0, "R6 flag persists", 8'h02);
        wr(1'b0, 8'h00);
        rd(1'b0, "R6 software clear", 8'h00);
        wr(1'b0, 8'hFF);
        rd(1'b0, "R6 bit 6 reads zero", 8'hBF);
        wr(1'b1, 8'hFF);
        rd(1'b1, "R6 option only bit 6", 8'h40);
        wr(1'b1, 8'h00);
        rd(1'b1, "R6 option cleared", 8'h00);
        wr(1'b0, 8'h00);

        // R8 request gating
        wr(1'b0, 8'h12);
        chk("R8 no gie no irq", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h92);
        chk("R8 gie and ext pair", {7'b0, irq}, 8'h01);
        wr(1'b0, 8'h82);
        chk("R8 flag without enable", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'hA4);
        chk("R8 timer pair", {7'b0, irq}, 8'h01);
        wr(1'b0, 8'h89);
        chk("R8 port pair", {7'b0, irq}, 8'h01);

        // R9 wake ignores gie
        wr(1'b0, 8'h12);
        sleeping = 1'b1;
        #1;
        chk("R9 wake without gie", {7'b0, wake}, 8'h01);
        chk("R9 no irq without gie", {7'b0, irq}, 8'h00);
        wr(1'b0, 8'h02);
        chk("R9 no wake without enable", {7'b0, wake}, 8'h00);
        sleeping = 1'b0;

        // R10 vector take and return
        wr(1'b0, 8'h92);
        vec_take = 1'b1;
        step(1);
        vec_take = 1'b0;
        rd(1'b0, "R10 vec_take clears gie", 8'h12);
        irq_return = 1'b1;
        step(1);
        irq_return = 1'b0;
        rd(1'b0, "R10 return sets gie", 8'h92);
        vec_take = 1'b1; irq_return = 1'b1;
        wr(1'b0, 8'h92);
        vec_take = 1'b0; irq_return = 1'b0;
        rd(1'b0, "R10 vec_take wins", 8'h12);
        wr(1'b0, 8'h00);

        // R4 timer wrap
        tmr_val = 8'hFE; step(1);
        tmr_val = 8'hFF; step(1);
        tmr_val = 8'h00; step(1);
        rd(1'b0, "R4 wrap sets bit 2", 8'h04);
        wr(1'b0, 8'h00);
        tmr_val = 8'h05; step(1);
        tmr_val = 8'h00; step(1);
        rd(1'b0, "R4 jump to zero ignored", 8'h00);
        tmr_val = 8'h01; step(1);
        rd(1'b0, "R4 step from zero ignored", 8'h00);
        tmr_val = 8'hFF; step(1);
        tmr_val = 8'h00; step(1);
        rd(1'b0, "R4 second wrap", 8'h04);
        wr(1'b0, 8'h00);

        // R5 port change
        port_hi = 4'h5;
        step(2);
        rd(1'b0, "R5 not yet after two edges", 8'h00);
        step(1);
        rd(1'b0, "R5 change sets bit 0", 8'h01);
        wr(1'b0, 8'h00);
        rd(1'b0, "R5 mismatch persists over clear", 8'h01);
        port_rd = 1'b1; step(1); port_rd = 1'b0;
        wr(1'b0, 8'h00);
        step(3);
        rd(1'b0, "R5 cleared after reference load", 8'h00);
        port_hi = 4'h4;
        step(3);
        rd(1'b0, "R5 single bit change", 8'h01);
        port_rd = 1'b1; step(1); port_rd = 1'b0;
        wr(1'b0, 8'h00);

        // R7 set wins over same-edge clear
        wr(1'b1, 8'h40);
        wr(1'b0, 8'h02);
        ext_pin = 1'b1;
        step(2);
        reg_wr = 1'b1; reg_sel = 1'b0; wr_data = 8'h00;
        step(1);
        reg_wr = 1'b0;
        rd(1'b0, "R7 set wins over clear", 8'h02);
        wr(1'b0, 8'h00);
        rd(1'b0, "R7 clear without event", 8'h00);

        step(2);
        done = 1'b1;
        summary();
        $finish;
    end
endmodule